// File: doc/BRIEF.md
# Per-Pin Interrupt Detector Bank

This block watches a 32-bit word of serially sampled GPIO inputs and turns changes or levels on each pin into sticky interrupt status. Every time the sampler upstream presents a fresh word with a one-cycle valid pulse, the block compares it with the previous valid word to find rising or falling edges. It can also test each pin against an active level. Per pin, three trigger-type bits choose the condition, an enable bit gates the pin onto the interrupt line, and a status bit records that the condition was seen.

Software reaches the bank through a simple register port: a byte address, a write strobe with write data, and combinational read data. Status is cleared by writing ones. The single interrupt output is asserted while any pin has both its status bit and its enable bit set.

Top module: `pin_irq_bank`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Registers are selected by `reg_addr[4:2]`, with bits 1:0 ignored. Byte offset 0x00 is enable, 0x04 is type0, 0x08 is type1, 0x0C is type2 and 0x10 is status. The first four read back what was written. A write to 0x10 never sets a bit. Offsets 0x14 to 0x1C read 0 and writes to them change nothing.
- R3: With type1=0, type2=0 and type0=1, a pin's status bit is set when the pin is 0 in one valid sample and 1 in the next. A 1-to-0 change does not set it.
- R4: With type1=0, type2=0 and type0=0, the status bit is set on a 1-to-0 change between valid samples and not on a 0-to-1 change.
- R5: With type1=0 and type2=1, either change sets the status bit, whatever type0 holds.
- R6: With type1=1, the pin is level-triggered. If type0=1 the status bit is set on every valid sample in which the pin is 1. If type0=0 it is set on every valid sample in which the pin is 0. Type2 has no effect in this mode.
- R7: Writing status with a 1 in bit n clears status bit n. Bits written with 0 keep their value.
- R8: If a clear and a detection hit the same bit in the same cycle, the bit ends up set.
- R9: Status bits are set whatever the enable bits hold. `irq` is high exactly when some pin n has both status bit n and enable bit n set.
- R10: Sample words presented without `samp_valid` are ignored, both for detection and as the reference for the next edge. The first valid sample after reset raises no edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_word | input | 32 | Sampled pin values, bit n = pin n |
| samp_valid | input | 1 | One-cycle pulse marking a new sample word |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined interrupt, high while any enabled pin has status set |

## Verification
The assertions take for granted that `samp_valid` is a single-cycle pulse and that register writes carry word-aligned offsets. Apart from that they assume nothing about the sample data, so detection-wins and stickiness are checked against any pattern. The stimulus drives every input on the falling clock edge, keeps each valid pulse to one cycle, and changes the sample word with the valid pulse low to show that such changes are ignored. It also lines up a status clear with a level detection in the same cycle.

// File: rtl/pin_irq_pkg.sv
// Shared definitions for the per-pin interrupt detector bank.
// Assumes a word-aligned byte address whose bits [4:2] pick the register.
package pin_irq_pkg;

    localparam int unsigned PIN_COUNT = 32;
    localparam int unsigned ADDR_W    = 5;

    typedef enum logic [2:0] {
        SEL_ENABLE = 3'd0,
        SEL_TYPE0  = 3'd1,
        SEL_TYPE1  = 3'd2,
        SEL_TYPE2  = 3'd3,
        SEL_STATUS = 3'd4,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    // Map a byte offset onto a register selector; holes decode to SEL_NONE.
    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        case (addr[4:2])
            3'd0:    return SEL_ENABLE;
            3'd1:    return SEL_TYPE0;
            3'd2:    return SEL_TYPE1;
            3'd3:    return SEL_TYPE2;
            3'd4:    return SEL_STATUS;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
// Configuration store: enable and the three trigger-type words.
// Assumes wr_sel is already decoded; status writes are not handled here.
module irq_cfg_regs
    import pin_irq_pkg::*;
#(
    parameter int unsigned NPINS = PIN_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] cfg_en,
    output logic [NPINS-1:0] cfg_t0,
    output logic [NPINS-1:0] cfg_t1,
    output logic [NPINS-1:0] cfg_t2
);

    // Capture configuration writes; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en <= '0;
            cfg_t0 <= '0;
            cfg_t1 <= '0;
            cfg_t2 <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ENABLE: cfg_en <= wr_data;
                SEL_TYPE0:  cfg_t0 <= wr_data;
                SEL_TYPE1:  cfg_t1 <= wr_data;
                SEL_TYPE2:  cfg_t2 <= wr_data;
                default:    ;
            endcase
        end
    end

    // R2: a write to the enable word is visible on the next cycle.
    p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ENABLE) |=> (cfg_en == $past(wr_data)));

    // R2: a write to a hole leaves the type words alone.
    p_hole_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_NONE) |=> ($stable(cfg_t0) && $stable(cfg_t1) && $stable(cfg_t2)));

endmodule

// File: rtl/irq_trigger_detect.sv
// Per-pin trigger detection. It compares each valid sample with the previous
// valid sample for edges, or tests the level. Edge detection is held off until
// a first valid sample has been stored as the reference.
// Assumes samp_valid is a single-cycle pulse per new word.
module irq_trigger_detect #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] samp_word,
    input  logic             samp_valid,
    input  logic [NPINS-1:0] cfg_t0,
    input  logic [NPINS-1:0] cfg_t1,
    input  logic [NPINS-1:0] cfg_t2,
    output logic [NPINS-1:0] hit
);

    logic [NPINS-1:0] prev_word;
    logic             primed;

    // Store the reference sample, only when a valid word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_word <= '0;
            primed    <= 1'b0;
        end else if (samp_valid) begin
            prev_word <= samp_word;
            primed    <= 1'b1;
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic rise, fall, edge_hit, level_hit;
        // Classify this pin's condition from the current and reference samples.
        always_comb begin
            rise      = samp_word[p] & ~prev_word[p];
            fall      = ~samp_word[p] & prev_word[p];
            edge_hit  = cfg_t2[p] ? (rise | fall) : (cfg_t0[p] ? rise : fall);
            level_hit = cfg_t0[p] ? samp_word[p] : ~samp_word[p];
            hit[p]    = samp_valid & (cfg_t1[p] ? level_hit : (primed & edge_hit));
        end
    end

    // R10: no event at all between valid samples.
    p_quiet_without_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |-> (hit == '0));

    // R10: no edge event before a reference sample exists.
    p_no_edge_unprimed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> ((hit & ~cfg_t1) == '0));

endmodule

// File: rtl/irq_status_store.sv
// Sticky status with write-one-to-clear and the masked interrupt combine.
// Assumes clr_mask is zero except in a status write cycle.
module irq_status_store #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] clr_mask,
    input  logic [NPINS-1:0] cfg_en,
    output logic [NPINS-1:0] status,
    output logic             irq
);

    // Set on detection, clear on write-one; detection has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | hit;
    end

    // Combine enabled status bits onto the single line.
    always_comb irq = |(status & cfg_en);

    // R8: every detection is present in status on the next cycle.
    p_detect_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(hit)) == $past(hit)));

    // R7: a bit only drops when a clear was written for it.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(clr_mask) & ~status) == '0));

    // R9: with all pins disabled the line stays low.
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en == '0) |-> !irq);

endmodule

// File: rtl/pin_irq_bank.sv
// Top of the per-pin interrupt detector bank: register decode and read mux
// around the configuration store, the trigger detectors and the status store.
// Assumes single-cycle write strobes and word-aligned offsets.
module pin_irq_bank
    import pin_irq_pkg::*;
#(
    parameter int unsigned NPINS = PIN_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  samp_word,
    input  logic              samp_valid,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              irq
);

    reg_sel_e         sel;
    logic [NPINS-1:0] cfg_en, cfg_t0, cfg_t1, cfg_t2;
    logic [NPINS-1:0] hit, status, clr_mask;

    // Decode the offset and build the write-one-to-clear mask.
    always_comb begin
        sel      = decode_sel(reg_addr);
        clr_mask = (reg_wr && sel == SEL_STATUS) ? reg_wdata : '0;
    end

    irq_cfg_regs #(.NPINS(NPINS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(sel), .wr_data(reg_wdata),
        .cfg_en(cfg_en), .cfg_t0(cfg_t0), .cfg_t1(cfg_t1), .cfg_t2(cfg_t2)
    );

    irq_trigger_detect #(.NPINS(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .samp_word(samp_word), .samp_valid(samp_valid),
        .cfg_t0(cfg_t0), .cfg_t1(cfg_t1), .cfg_t2(cfg_t2), .hit(hit)
    );

    irq_status_store #(.NPINS(NPINS)) u_stat (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr_mask(clr_mask), .cfg_en(cfg_en),
        .status(status), .irq(irq)
    );

    // Return the addressed register; holes read zero.
    always_comb begin
        case (sel)
            SEL_ENABLE: reg_rdata = cfg_en;
            SEL_TYPE0:  reg_rdata = cfg_t0;
            SEL_TYPE1:  reg_rdata = cfg_t1;
            SEL_TYPE2:  reg_rdata = cfg_t2;
            SEL_STATUS: reg_rdata = status;
            default:    reg_rdata = '0;
        endcase
    end

    // R1: the line is low in the first cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !irq);

endmodule

// File: tb/tb_pin_irq_bank.sv
module tb_pin_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] samp_word = '0;
    logic        samp_valid = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [4:0] A_EN = 5'h00, A_T0 = 5'h04, A_T1 = 5'h08,
                           A_T2 = 5'h0C, A_ST = 5'h10, A_HOLE = 5'h14;

    pin_irq_bank dut (
        .clk(clk), .rst_n(rst_n), .samp_word(samp_word), .samp_valid(samp_valid),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: optional write and optional sample, driven on the falling edge.
    task automatic cyc(input logic wr, input logic [4:0] a, input logic [31:0] d,
                       input logic v, input logic [31:0] w);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        samp_valid = v; samp_word = w;
        @(negedge clk);
        reg_wr = 1'b0; samp_valid = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, samp_word);
    endtask

    task automatic smp(input logic [31:0] w);
        cyc(1'b0, reg_addr, '0, 1'b1, w);
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 enable", A_EN, 0);
        rd_chk("R1 type0", A_T0, 0);
        rd_chk("R1 type1", A_T1, 0);
        rd_chk("R1 type2", A_T2, 0);
        rd_chk("R1 status", A_ST, 0);
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_regmap;
        wr(A_EN, 32'hA5A5_0000); wr(A_T0, 32'h1234_5678);
        wr(A_T1, 32'h0F0F_0000); wr(A_T2, 32'hCAFE_0000);
        rd_chk("R2 enable", A_EN, 32'hA5A5_0000);
        rd_chk("R2 type0", A_T0, 32'h1234_5678);
        rd_chk("R2 type1", A_T1, 32'h0F0F_0000);
        rd_chk("R2 type2", A_T2, 32'hCAFE_0000);
        wr(A_HOLE, 32'hFFFF_FFFF);
        rd_chk("R2 hole read", A_HOLE, 0);
        rd_chk("R2 hole no effect", A_T0, 32'h1234_5678);
        wr(A_ST, 32'hFFFF_FFFF);
        rd_chk("R2 status write no set", A_ST, 0);
        wr(A_EN, 0); wr(A_T0, 0); wr(A_T1, 0); wr(A_T2, 0);
    endtask

    task automatic t_rise_and_valid;
        wr(A_T0, 32'hFFFF_FFFF);
        smp(32'hFFFF_FFFF);
        rd_chk("R10 first sample no edge", A_ST, 0);
        smp(32'h0000_0000);
        rd_chk("R3 falling ignored", A_ST, 0);
        smp(32'h0000_00F0);
        rd_chk("R3 rising sets", A_ST, 32'h0000_00F0);
        @(negedge clk); samp_word = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rd_chk("R10 no valid ignored", A_ST, 32'h0000_00F0);
        smp(32'h0000_00F0);
        rd_chk("R10 reference kept", A_ST, 32'h0000_00F0);
    endtask

    task automatic t_clear;
        wr(A_ST, 32'h0000_0030);
        rd_chk("R7 partial clear", A_ST, 32'h0000_00C0);
        wr(A_ST, 32'h0000_0000);
        rd_chk("R7 zero write keeps", A_ST, 32'h0000_00C0);
        wr(A_ST, 32'hFFFF_FFFF);
        rd_chk("R7 full clear", A_ST, 0);
    endtask

    task automatic t_fall;
        wr(A_T0, 0);
        smp(32'h0000_0000);
        rd_chk("R4 falling sets", A_ST, 32'h0000_00F0);
        smp(32'h0000_0F00);
        rd_chk("R4 rising ignored", A_ST, 32'h0000_00F0);
        smp(32'h0000_0000);
        wr(A_ST, 32'hFFFF_FFFF);
    endtask

    task automatic t_both;
        wr(A_T2, 32'h0000_FFFF); wr(A_T0, 32'h0000_00FF);
        smp(32'hF000_0F0F);
        rd_chk("R5 dual rising", A_ST, 32'h0000_0F0F);
        wr(A_ST, 32'hFFFF_FFFF);
        smp(32'h0000_0000);
        rd_chk("R5 dual falling", A_ST, 32'hF000_0F0F);
        wr(A_ST, 32'hFFFF_FFFF);
    endtask

    task automatic t_level;
        wr(A_T1, 32'hFFFF_FFFF); wr(A_T0, 32'h0000_FFFF); wr(A_T2, 32'hFFFF_FFFF);
        smp(32'h00FF_00FF);
        rd_chk("R6 level high and low", A_ST, 32'hFF00_00FF);
        wr(A_ST, 32'hFFFF_FFFF);
        rd_chk("R6 cleared", A_ST, 0);
        smp(32'h00FF_00FF);
        rd_chk("R6 re-set each sample", A_ST, 32'hFF00_00FF);
    endtask

    task automatic t_race;
        cyc(1'b1, A_ST, 32'hFFFF_FFFF, 1'b1, 32'h0000_0001);
        rd_chk("R8 detect wins clear", A_ST, 32'hFFFF_0001);
    endtask

    task automatic t_irq;
        chk("R9 status set while disabled irq low", {31'd0, irq}, 0);
        wr(A_EN, 32'h0000_0002);
        #1 chk("R9 enable on idle pin", {31'd0, irq}, 0);
        wr(A_EN, 32'h0000_0001);
        #1 chk("R9 enabled pin raises irq", {31'd0, irq}, 1);
        wr(A_ST, 32'h0000_0001);
        #1 chk("R9 irq drops on clear", {31'd0, irq}, 0);
    endtask

    initial begin
        #200_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_rise_and_valid();
        t_clear();
        t_fall();
        t_both();
        t_level();
        t_race();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule